// File: doc/BRIEF.md
# Dual Alarm Comparator with Shared Interrupt / Square-Wave Pin

This block sits beside the calendar counters of a real-time clock. It holds two alarm settings and compares each of them with the live seconds, minutes, hours, day-of-week and date fields whenever the calendar signals that a new second has begun. Each alarm carries per-field ignore bits. With these bits an alarm can fire once at a full date-and-time, or it can repeat every day, hour, minute or second. A match sets a sticky flag for that alarm, and the flag stays set until software clears it.

One open-drain style output pin serves two purposes. With square-wave mode off, the pin is pulled low while any flag whose interrupt enable is set is raised. With square-wave mode on, the pin carries a 50% duty square wave divided from the crystal, at one of four selectable rates. Selecting a new rate, or enabling the mode, restarts the divider from a clean low phase.

The crystal is presented as `osc_edge`, a one-cycle pulse on every edge of the 32.768 kHz oscillator. That gives `EDGE_RATE` = 65,536 pulses per second.

Top module: `rtc_alarm_sqw`

## Requirements
- R1: During reset and on the cycle after it, both alarm flags read 0. With `sqw_en` low, `pin_n` reads 1 after reset.
- R2: Ignore code 4'b1111 (bit 0 second, bit 1 minute, bit 2 hour, bit 3 day/date; 1 means ignore) sets the flag on every `sec_tick`, whatever the field values. Without `sec_tick`, no flag is set, even if the fields match.
- R3: Ignore code 4'b1110 sets the flag on `sec_tick` only when the seconds are equal.
- R4: Ignore code 4'b1100 needs both minutes and seconds to be equal. A minute mismatch leaves the flag at 0.
- R5: Ignore code 4'b1000 needs hours, minutes and seconds to be equal. The date is ignored.
- R6: Ignore code 4'b0000 with `alm_day_sel`=0 also needs the date to equal `alm_daydate`.
- R7: Ignore code 4'b0000 with `alm_day_sel`=1 compares the low 3 bits of `alm_daydate` with `cal_dow`. The date is ignored.
- R8: A flag is sticky. It stays at 1 after the fields stop matching and falls to 0 only on a cycle with its `flag_clr` bit high. A new match in that same cycle wins, and the flag stays at 1.
- R9: The alarms are independent. A match of one alarm never sets the other alarm's flag.
- R10: With `sqw_en`=0, `pin_n` is 0 exactly when some flag is 1 and its `irq_en` bit is 1. Otherwise `pin_n` is 1.
- R11: With `sqw_en`=1, the flags are ignored and `pin_n` is a square wave. Each half-period lasts this many `osc_edge` pulses, by `rate_sel`: 0 gives 32768 (1 Hz), 1 gives 8 (4.096 kHz), 2 gives 4 (8.192 kHz), 3 gives 1 (32.768 kHz). The high and low halves are equal.
- R12: Enabling square-wave mode, or changing `rate_sel` while it is on, restarts the divider. From the next cycle `pin_n` is 0 for one full half-period, then toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_edge | input | 1 | One-cycle pulse per oscillator edge (65,536 per second) |
| sec_tick | input | 1 | One-cycle pulse when the calendar seconds advance |
| cal_sec | input | 7 | Live seconds |
| cal_min | input | 7 | Live minutes |
| cal_hour | input | 6 | Live hours |
| cal_dow | input | 3 | Live day of week |
| cal_date | input | 6 | Live day of month |
| alm_sec | input | 2x7 | Alarm seconds, one per alarm |
| alm_min | input | 2x7 | Alarm minutes |
| alm_hour | input | 2x6 | Alarm hours |
| alm_daydate | input | 2x6 | Alarm date, or day of week in the low 3 bits |
| alm_mask | input | 2x4 | Per-field ignore bits |
| alm_day_sel | input | 2 | 1: compare day of week, 0: compare date |
| irq_en | input | 2 | Interrupt enable per alarm |
| flag_clr | input | 2 | Software write of 0 to the flag, one pulse per alarm |
| sqw_en | input | 1 | 1 selects square wave on the pin |
| rate_sel | input | 2 | Square-wave rate code |
| alarm_flag | output | 2 | Sticky alarm flags |
| pin_n | output | 1 | Shared active-low output |

## Verification
The bench walks each ignore code across a near miss and an exact match. A comparator that skipped one field, or wired the day/date select backwards, would set a flag on the near miss. It then raises a set and a clear in the same cycle; a design that let the clear win would drop an alarm that had just arrived. Each of the four rates is measured over a full low and high half, which exposes divide counts that are off by one and an unequal duty cycle. A rate change made halfway through a period shows whether the divider truly restarts, or carries a stale count into the new rate.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int unsigned OSC_HZ   = 32768;
   localparam int unsigned FIELD_N  = 4;
   localparam int unsigned F_SEC    = 0;
   localparam int unsigned F_MIN    = 1;
   localparam int unsigned F_HOUR   = 2;
   localparam int unsigned F_DAY    = 3;

   typedef enum logic [1:0] {
      RATE_1HZ  = 2'd0,
      RATE_4K   = 2'd1,
      RATE_8K   = 2'd2,
      RATE_32K  = 2'd3
   } sqw_rate_e;

   // edges of the crystal per half-period of the selected wave
   function automatic int unsigned half_edges(int unsigned edge_rate, sqw_rate_e r);
      case (r)
         RATE_1HZ: return edge_rate / 2;
         RATE_4K:  return edge_rate / 8192;
         RATE_8K:  return edge_rate / 16384;
         default:  return edge_rate / 65536;
      endcase
   endfunction
endpackage

// File: rtl/alarm_unit.sv
module alarm_unit
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned SEC_W  = 7,
   parameter int unsigned MIN_W  = 7,
   parameter int unsigned HOUR_W = 6,
   parameter int unsigned DOW_W  = 3,
   parameter int unsigned DATE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_tick,
   input  logic [SEC_W-1:0]   cal_sec,
   input  logic [MIN_W-1:0]   cal_min,
   input  logic [HOUR_W-1:0]  cal_hour,
   input  logic [DOW_W-1:0]   cal_dow,
   input  logic [DATE_W-1:0]  cal_date,
   input  logic [SEC_W-1:0]   set_sec,
   input  logic [MIN_W-1:0]   set_min,
   input  logic [HOUR_W-1:0]  set_hour,
   input  logic [DATE_W-1:0]  set_daydate,
   input  logic [FIELD_N-1:0] ignore,
   input  logic               day_sel,
   input  logic               clr,
   output logic               flag
);
   logic [FIELD_N-1:0] field_eq;
   logic               hit;

   always_comb begin
      field_eq         = '0;
      field_eq[F_SEC]  = (cal_sec  == set_sec);
      field_eq[F_MIN]  = (cal_min  == set_min);
      field_eq[F_HOUR] = (cal_hour == set_hour);
      field_eq[F_DAY]  = day_sel ? (cal_dow == set_daydate[DOW_W-1:0])
                                 : (cal_date == set_daydate);
   end

   // each field either matches or is ignored
   assign hit = &(field_eq | ignore);

   // a new match outranks a software clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~clr) | (sec_tick & hit);
   end
endmodule

// File: rtl/rate_divider.sv
module rate_divider
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned EDGE_RATE = 65536
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_edge,
   input  logic       en,
   input  logic [1:0] rate_sel,
   output logic       sq
);
   localparam int unsigned HALF_MAX = EDGE_RATE / 2;
   localparam int unsigned CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
   localparam int unsigned LIM_1HZ  = half_edges(EDGE_RATE, RATE_1HZ) - 1;
   localparam int unsigned LIM_4K   = half_edges(EDGE_RATE, RATE_4K)  - 1;
   localparam int unsigned LIM_8K   = half_edges(EDGE_RATE, RATE_8K)  - 1;
   localparam int unsigned LIM_32K  = half_edges(EDGE_RATE, RATE_32K) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic [1:0]       rate_q;
   logic             en_q;
   logic             restart;

   always_comb begin
      case (sqw_rate_e'(rate_sel))
         RATE_1HZ: limit = CNT_W'(LIM_1HZ);
         RATE_4K:  limit = CNT_W'(LIM_4K);
         RATE_8K:  limit = CNT_W'(LIM_8K);
         default:  limit = CNT_W'(LIM_32K);
      endcase
   end

   // a fresh enable or a new rate code starts a clean low phase
   assign restart = !en || !en_q || (rate_sel != rate_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         sq     <= 1'b0;
         rate_q <= '0;
         en_q   <= 1'b0;
      end else begin
         rate_q <= rate_sel;
         en_q   <= en;
         if (restart) begin
            cnt <= '0;
            sq  <= 1'b0;
         end else if (osc_edge) begin
            if (cnt == limit) begin
               cnt <= '0;
               sq  <= ~sq;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/out_select.sv
module out_select #(
   parameter int unsigned N_ALARMS = 2
) (
   input  logic                sqw_en,
   input  logic                sq,
   input  logic [N_ALARMS-1:0] flags,
   input  logic [N_ALARMS-1:0] irq_en,
   output logic                pin_n
);
   logic irq_any;
   assign irq_any = |(flags & irq_en);
   assign pin_n   = sqw_en ? sq : ~irq_any;
endmodule

// File: rtl/rtc_alarm_sqw.sv
module rtc_alarm_sqw
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned N_ALARMS  = 2,
   parameter int unsigned SEC_W     = 7,
   parameter int unsigned MIN_W     = 7,
   parameter int unsigned HOUR_W    = 6,
   parameter int unsigned DOW_W     = 3,
   parameter int unsigned DATE_W    = 6,
   parameter int unsigned EDGE_RATE = 65536
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            osc_edge,
   input  logic                            sec_tick,
   input  logic [SEC_W-1:0]                cal_sec,
   input  logic [MIN_W-1:0]                cal_min,
   input  logic [HOUR_W-1:0]               cal_hour,
   input  logic [DOW_W-1:0]                cal_dow,
   input  logic [DATE_W-1:0]               cal_date,
   input  logic [N_ALARMS-1:0][SEC_W-1:0]  alm_sec,
   input  logic [N_ALARMS-1:0][MIN_W-1:0]  alm_min,
   input  logic [N_ALARMS-1:0][HOUR_W-1:0] alm_hour,
   input  logic [N_ALARMS-1:0][DATE_W-1:0] alm_daydate,
   input  logic [N_ALARMS-1:0][FIELD_N-1:0] alm_mask,
   input  logic [N_ALARMS-1:0]             alm_day_sel,
   input  logic [N_ALARMS-1:0]             irq_en,
   input  logic [N_ALARMS-1:0]             flag_clr,
   input  logic                            sqw_en,
   input  logic [1:0]                      rate_sel,
   output logic [N_ALARMS-1:0]             alarm_flag,
   output logic                            pin_n
);
   // elaboration-time parameter checks
   if (N_ALARMS < 1) begin : g_bad_count
      $error("rtc_alarm_sqw: N_ALARMS must be at least 1");
   end
   if (DOW_W > DATE_W) begin : g_bad_dow
      $error("rtc_alarm_sqw: DOW_W must not exceed DATE_W");
   end
   if ((EDGE_RATE == 0) || ((EDGE_RATE % 65536) != 0)) begin : g_bad_rate
      $error("rtc_alarm_sqw: EDGE_RATE must be a nonzero multiple of 65536");
   end

   logic sq;

   for (genvar i = 0; i < N_ALARMS; i++) begin : g_alarm
      alarm_unit #(
         .SEC_W (SEC_W), .MIN_W (MIN_W), .HOUR_W (HOUR_W),
         .DOW_W (DOW_W), .DATE_W(DATE_W)
      ) u_alarm (
         .clk        (clk),
         .rst_n      (rst_n),
         .sec_tick   (sec_tick),
         .cal_sec    (cal_sec),
         .cal_min    (cal_min),
         .cal_hour   (cal_hour),
         .cal_dow    (cal_dow),
         .cal_date   (cal_date),
         .set_sec    (alm_sec[i]),
         .set_min    (alm_min[i]),
         .set_hour   (alm_hour[i]),
         .set_daydate(alm_daydate[i]),
         .ignore     (alm_mask[i]),
         .day_sel    (alm_day_sel[i]),
         .clr        (flag_clr[i]),
         .flag       (alarm_flag[i])
      );
   end

   rate_divider #(.EDGE_RATE(EDGE_RATE)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc_edge(osc_edge),
      .en      (sqw_en),
      .rate_sel(rate_sel),
      .sq      (sq)
   );

   out_select #(.N_ALARMS(N_ALARMS)) u_out (
      .sqw_en(sqw_en),
      .sq    (sq),
      .flags (alarm_flag),
      .irq_en(irq_en),
      .pin_n (pin_n)
   );
endmodule

// File: rtl/rtc_alarm_sqw_chk.sv
module rtc_alarm_sqw_chk #(
   parameter int unsigned N_ALARMS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                osc_edge,
   input logic                sec_tick,
   input logic [N_ALARMS-1:0] irq_en,
   input logic [N_ALARMS-1:0] flag_clr,
   input logic                sqw_en,
   input logic [1:0]          rate_sel,
   input logic [N_ALARMS-1:0] alarm_flag,
   input logic                pin_n
);
   // R1: reset clears every flag
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (alarm_flag == '0));

   for (genvar i = 0; i < N_ALARMS; i++) begin : g_flag
      // R2: no second tick, no new flag
      a_r2_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
         (!sec_tick && !alarm_flag[i]) |=> !alarm_flag[i]);
      // R8: a raised flag holds until cleared
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (alarm_flag[i] && !flag_clr[i]) |=> alarm_flag[i]);
   end

   // R10: interrupt mode drives the pin from enabled flags
   a_r10_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sqw_en && |(alarm_flag & irq_en)) |-> !pin_n);
   a_r10_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!sqw_en && !(|(alarm_flag & irq_en))) |-> pin_n);

   // R11: the fastest rate flips the pin on every crystal edge
   a_r11_fast_rate_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (sqw_en && $past(sqw_en) && $past(sqw_en, 2) && $past(rst_n) && $past(rst_n, 2)
       && $past(rate_sel) == 2'd3 && $past(rate_sel, 2) == 2'd3 && $past(osc_edge))
      |-> (pin_n != $past(pin_n)));

   // R12: a new rate or a fresh enable starts low
   a_r12_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sqw_en && (rate_sel != $past(rate_sel) || !$past(sqw_en))) |=> (!sqw_en || !pin_n));
endmodule

bind rtc_alarm_sqw rtc_alarm_sqw_chk #(.N_ALARMS(N_ALARMS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .osc_edge  (osc_edge),
   .sec_tick  (sec_tick),
   .irq_en    (irq_en),
   .flag_clr  (flag_clr),
   .sqw_en    (sqw_en),
   .rate_sel  (rate_sel),
   .alarm_flag(alarm_flag),
   .pin_n     (pin_n)
);

// File: tb/tb_rtc_alarm_sqw.sv
module tb_rtc_alarm_sqw;
   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            osc_edge = 1'b0;
   logic            sec_tick = 1'b0;
   logic [6:0]      cal_sec = '0;
   logic [6:0]      cal_min = '0;
   logic [5:0]      cal_hour = '0;
   logic [2:0]      cal_dow = '0;
   logic [5:0]      cal_date = '0;
   logic [1:0][6:0] alm_sec = '0;
   logic [1:0][6:0] alm_min = '0;
   logic [1:0][5:0] alm_hour = '0;
   logic [1:0][5:0] alm_daydate = '0;
   logic [1:0][3:0] alm_mask = '0;
   logic [1:0]      alm_day_sel = '0;
   logic [1:0]      irq_en = '0;
   logic [1:0]      flag_clr = '0;
   logic            sqw_en = 1'b0;
   logic [1:0]      rate_sel = '0;
   logic [1:0]      alarm_flag;
   logic            pin_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rtc_alarm_sqw dut (
      .clk(clk), .rst_n(rst_n), .osc_edge(osc_edge), .sec_tick(sec_tick),
      .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
      .cal_dow(cal_dow), .cal_date(cal_date),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
      .alm_daydate(alm_daydate), .alm_mask(alm_mask), .alm_day_sel(alm_day_sel),
      .irq_en(irq_en), .flag_clr(flag_clr), .sqw_en(sqw_en), .rate_sel(rate_sel),
      .alarm_flag(alarm_flag), .pin_n(pin_n)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_alarm(int idx, logic [3:0] msk, logic dsel, int dd, int hr, int mn, int sc);
      alm_mask[idx]    = msk;
      alm_day_sel[idx] = dsel;
      alm_daydate[idx] = 6'(dd);
      alm_hour[idx]    = 6'(hr);
      alm_min[idx]     = 7'(mn);
      alm_sec[idx]     = 7'(sc);
   endtask

   task automatic set_cal(int dw, int dt, int hr, int mn, int sc);
      cal_dow  = 3'(dw);
      cal_date = 6'(dt);
      cal_hour = 6'(hr);
      cal_min  = 7'(mn);
      cal_sec  = 7'(sc);
   endtask

   // called at a negedge; returns at the next negedge with the flag visible
   task automatic pulse_tick();
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic clear_all();
      flag_clr = 2'b11;
      @(negedge clk);
      flag_clr = 2'b00;
   endtask

   task automatic t_reset();
      chk("R1", "flags after reset", alarm_flag, 0);
      chk("R1", "pin after reset", pin_n, 1);
   endtask

   task automatic t_every_second();
      set_alarm(1, 4'b1110, 1'b0, 1, 0, 0, 99);
      set_alarm(0, 4'b1111, 1'b0, 3, 4, 5, 6);
      set_cal(2, 9, 10, 11, 12);
      repeat (3) @(negedge clk);
      chk("R2", "no tick leaves flag clear", alarm_flag[0], 0);
      pulse_tick();
      chk("R2", "every-second tick sets flag", alarm_flag[0], 1);
      clear_all();
   endtask

   task automatic t_second_match();
      set_alarm(0, 4'b1110, 1'b0, 1, 1, 1, 30);
      set_cal(0, 2, 3, 4, 29);
      pulse_tick();
      chk("R3", "seconds differ", alarm_flag[0], 0);
      set_cal(0, 2, 3, 4, 30);
      pulse_tick();
      chk("R3", "seconds equal", alarm_flag[0], 1);
      clear_all();
   endtask

   task automatic t_min_sec();
      set_alarm(0, 4'b1100, 1'b0, 1, 1, 15, 30);
      set_cal(0, 2, 3, 16, 30);
      pulse_tick();
      chk("R4", "minute differs", alarm_flag[0], 0);
      set_cal(0, 2, 7, 15, 30);
      pulse_tick();
      chk("R4", "minute and second equal", alarm_flag[0], 1);
      clear_all();
   endtask

   task automatic t_hms();
      set_alarm(0, 4'b1000, 1'b0, 1, 8, 15, 30);
      set_cal(0, 2, 9, 15, 30);
      pulse_tick();
      chk("R5", "hour differs", alarm_flag[0], 0);
      set_cal(0, 25, 8, 15, 30);
      pulse_tick();
      chk("R5", "h:m:s equal, date ignored", alarm_flag[0], 1);
      clear_all();
   endtask

   task automatic t_date();
      set_alarm(0, 4'b0000, 1'b0, 12, 8, 15, 30);
      set_cal(3, 11, 8, 15, 30);
      pulse_tick();
      chk("R6", "date differs", alarm_flag[0], 0);
      set_cal(6, 12, 8, 15, 30);
      pulse_tick();
      chk("R6", "full date match", alarm_flag[0], 1);
      clear_all();
   endtask

   task automatic t_dow();
      set_alarm(0, 4'b0000, 1'b1, 5, 8, 15, 30);
      set_cal(4, 5, 8, 15, 30);
      pulse_tick();
      chk("R7", "day of week differs while date equals", alarm_flag[0], 0);
      set_cal(5, 20, 8, 15, 30);
      pulse_tick();
      chk("R7", "day of week match", alarm_flag[0], 1);
      clear_all();
   endtask

   task automatic t_sticky();
      set_alarm(0, 4'b1110, 1'b0, 1, 1, 1, 40);
      set_cal(0, 1, 1, 1, 40);
      pulse_tick();
      set_cal(0, 1, 1, 1, 41);
      pulse_tick();
      repeat (4) @(negedge clk);
      chk("R8", "flag holds after mismatch", alarm_flag[0], 1);
      flag_clr = 2'b01;
      @(negedge clk);
      flag_clr = 2'b00;
      chk("R8", "flag clears on write", alarm_flag[0], 0);
      set_cal(0, 1, 1, 1, 40);
      pulse_tick();
      flag_clr = 2'b01;
      pulse_tick();
      flag_clr = 2'b00;
      chk("R8", "match wins over same-cycle clear", alarm_flag[0], 1);
      clear_all();
   endtask

   task automatic t_independent();
      set_alarm(0, 4'b1110, 1'b0, 1, 1, 1, 8);
      set_alarm(1, 4'b1110, 1'b0, 1, 1, 1, 7);
      set_cal(0, 1, 1, 1, 7);
      pulse_tick();
      chk("R9", "only alarm 1 flagged", alarm_flag, 2);
      set_cal(0, 1, 1, 1, 8);
      pulse_tick();
      chk("R9", "alarm 0 flags on its own match", alarm_flag, 3);
      clear_all();
   endtask

   task automatic t_pin_irq();
      set_alarm(0, 4'b1110, 1'b0, 1, 1, 1, 50);
      set_alarm(1, 4'b1111, 1'b0, 1, 1, 1, 1);
      set_cal(0, 1, 1, 1, 2);
      pulse_tick();
      irq_en = 2'b01;
      @(negedge clk);
      chk("R10", "flag without enable keeps pin high", pin_n, 1);
      irq_en = 2'b10;
      @(negedge clk);
      chk("R10", "enabled flag pulls pin low", pin_n, 0);
      clear_all();
      chk("R10", "pin released after clear", pin_n, 1);
   endtask

   task automatic measure(int sel, int half, string tag);
      int lo = 0;
      int hi = 0;
      rate_sel = 2'(sel);
      sqw_en   = 1'b1;
      @(negedge clk);
      chk("R12", {tag, " starts low"}, pin_n, 0);
      while (pin_n == 1'b0 && lo < 70000) begin
         lo++;
         @(negedge clk);
      end
      while (pin_n == 1'b1 && hi < 70000) begin
         hi++;
         @(negedge clk);
      end
      chk("R11", {tag, " low half"}, lo, half);
      chk("R11", {tag, " high half"}, hi, half);
   endtask

   task automatic t_square_wave();
      set_alarm(0, 4'b1111, 1'b0, 1, 1, 1, 1);
      pulse_tick();
      irq_en   = 2'b11;
      osc_edge = 1'b1;
      @(negedge clk);
      chk("R10", "pin low before wave mode", pin_n, 0);
      measure(3, 1, "32.768 kHz");
      measure(2, 4, "8.192 kHz");
      measure(1, 8, "4.096 kHz");
      repeat (5) @(negedge clk);
      measure(2, 4, "restart mid-period");
      measure(0, 32768, "1 Hz");
      sqw_en = 1'b0;
      @(negedge clk);
      chk("R11", "interrupt returns when wave off", pin_n, 0);
      osc_edge = 1'b0;
      clear_all();
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_every_second();
      t_second_match();
      t_min_sec();
      t_hms();
      t_date();
      t_dow();
      t_sticky();
      t_independent();
      t_pin_irq();
      t_square_wave();
      finish_run();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule